// File: doc/BRIEF.md
# Four-Line Instruction Line Buffer

This block sits between an instruction fetch stage and a shared memory that returns 256 bits per read. It keeps four lines, each holding eight 32-bit instruction words taken from one eight-word-aligned block of the shared memory. The fetch stage presents a word address each cycle. On a hit, the instruction word is read straight out of the line buffer and handed to the pipeline. Nothing is copied into local register memory first.

On a miss the block raises a fill request naming the aligned block. The pipeline holds its fetch address until the word arrives. A surrounding controller picks the victim line and the memory slot. It then returns the whole line in one transfer, together with the way to write and the block number. In the cycle that transfer lands, the requested word is forwarded to the pipeline directly from the fill data. This means that when the fill slot is aligned with the miss, the miss costs no cycle beyond the fill itself. Any loop whose code fits inside four aligned blocks stays resident once those blocks are loaded.

Top module: `iline_buf`

## Requirements
- R1: After reset, rd_valid, rd_fwd and miss_req are low and no line is valid, so the first fetch of any address misses.
- R2: A fetch whose block (address bits above [2:0]) is neither resident nor arriving on the fill port raises miss_req on the following cycle, with miss_blk equal to that block and rd_valid low. miss_req stays high for as long as the same fetch is held and no matching fill arrives.
- R3: When fill_valid is high at the same edge as a fetch whose block equals fill_blk, the next cycle shows rd_valid=1 and rd_fwd=1. rd_word is then word k of fill_data, where k is address bits [2:0] and word k occupies bits [32k+31:32k].
- R4: After a line has been filled, a fetch of any of its eight words gives rd_valid=1, rd_fwd=0, miss_req=0 and the stored word on the next cycle.
- R5: Lines are aligned to eight words. Addresses that differ only in bits [2:0] share one line, including entry in the middle of a line, while the address one past the line's last word misses.
- R6: A fill writes only the line selected by fill_way. The block that way held before then misses, and the other three lines keep hitting.
- R7: With four distinct aligned blocks loaded, fetches of all 32 words hit, and none of them raises miss_req.
- R8: flush clears every line's valid bit. A fetch presented in the flush cycle yields neither rd_valid nor miss_req, and a fill presented in the same cycle is discarded.
- R9: When fetch_valid is low, rd_valid and miss_req are low on the next cycle. A fill alone delivers nothing.
- R10: rd_valid and miss_req are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all lines |
| fetch_valid | input | 1 | A fetch address is presented |
| fetch_addr | input | ADDR_W | Word address of the fetch |
| fill_valid | input | 1 | A line transfer lands this cycle |
| fill_way | input | log2(LINES) | Line to write |
| fill_blk | input | ADDR_W-3 | Block number of the transfer |
| fill_data | input | 256 | Eight words, word k in bits [32k+31:32k] |
| rd_valid | output | 1 | rd_word holds the fetched instruction |
| rd_fwd | output | 1 | The word was forwarded from a landing fill |
| rd_word | output | 32 | Instruction word |
| miss_req | output | 1 | Fill request for miss_blk |
| miss_blk | output | ADDR_W-3 | Block number requested |

## Verification
Every result is registered once. rd_valid, rd_fwd, rd_word, miss_req and miss_blk therefore all reflect the fetch, fill and flush inputs sampled at the previous rising edge. A line written by a fill can be hit by a fetch at the very next edge. The bench drives inputs on falling edges and samples on the following falling edge, which means each check reads the response to exactly one edge. Multi-step scenarios, such as a miss followed by a fill and then a hit, advance one edge per step and check after every step.

// File: rtl/ilb_pkg.sv
package ilb_pkg;
  localparam int unsigned DEF_ADDR_W     = 16;
  localparam int unsigned DEF_WORD_W     = 32;
  localparam int unsigned DEF_LINE_WORDS = 8;
  localparam int unsigned DEF_LINES      = 4;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HIT  = 2'd1,
    SRC_FILL = 2'd2
  } deliver_src_e;
endpackage

// File: rtl/ilb_tag_store.sv
module ilb_tag_store #(
  parameter int unsigned LINES = 4,
  parameter int unsigned BLK_W = 13,
  localparam int unsigned WAY_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [BLK_W-1:0] fill_blk,
  input  logic [BLK_W-1:0] look_blk,
  output logic [LINES-1:0] match_vec
);
  logic [LINES-1:0] valid_q;
  logic [BLK_W-1:0] tag_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        valid_q[i] <= 1'b0;
      end else if (fill_en && fill_way == WAY_W'(i)) begin
        valid_q[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!flush && fill_en && fill_way == WAY_W'(i)) begin
        tag_q[i] <= fill_blk;
      end
    end

    assign match_vec[i] = valid_q[i] && (tag_q[i] == look_blk);
  end

  // R5
  tag_unique_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  // R6
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush) |=> valid_q[$past(fill_way)]);

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0));
endmodule

// File: rtl/ilb_data_store.sv
module ilb_data_store #(
  parameter int unsigned LINES      = 4,
  parameter int unsigned LINE_WORDS = 8,
  parameter int unsigned WORD_W     = 32,
  localparam int unsigned WAY_W     = $clog2(LINES),
  localparam int unsigned OFS_W     = $clog2(LINE_WORDS),
  localparam int unsigned LINE_BITS = LINE_WORDS * WORD_W
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [WAY_W-1:0]     wr_way,
  input  logic [LINE_BITS-1:0] wr_line,
  input  logic [WAY_W-1:0]     rd_way,
  input  logic [OFS_W-1:0]     rd_sel,
  input  logic                 byp_en,
  output logic [WORD_W-1:0]    word_q
);
  logic [LINE_BITS-1:0] mem [LINES];
  logic [LINE_BITS-1:0] rd_line;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_way] <= wr_line;
    end
  end

  assign rd_line = byp_en ? wr_line : mem[rd_way];

  always_ff @(posedge clk) begin
    word_q <= rd_line[rd_sel*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/iline_buf.sv
module iline_buf
  import ilb_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned WORD_W     = DEF_WORD_W,
  parameter int unsigned LINE_WORDS = DEF_LINE_WORDS,
  parameter int unsigned LINES      = DEF_LINES
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      flush,
  input  logic                                      fetch_valid,
  input  logic [ADDR_W-1:0]                         fetch_addr,
  input  logic                                      fill_valid,
  input  logic [$clog2(LINES)-1:0]                  fill_way,
  input  logic [ADDR_W-$clog2(LINE_WORDS)-1:0]      fill_blk,
  input  logic [LINE_WORDS*WORD_W-1:0]              fill_data,
  output logic                                      rd_valid,
  output logic                                      rd_fwd,
  output logic [WORD_W-1:0]                         rd_word,
  output logic                                      miss_req,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]      miss_blk
);
  localparam int unsigned OFS_W = $clog2(LINE_WORDS);
  localparam int unsigned BLK_W = ADDR_W - OFS_W;
  localparam int unsigned WAY_W = $clog2(LINES);

  logic [BLK_W-1:0] cur_blk;
  logic [OFS_W-1:0] cur_sel;
  logic [LINES-1:0] match_vec;
  logic             any_hit;
  logic [WAY_W-1:0] hit_way;
  logic             fill_en;
  logic             fill_match;
  deliver_src_e     src;

  assign cur_blk = fetch_addr[ADDR_W-1:OFS_W];
  assign cur_sel = fetch_addr[OFS_W-1:0];
  assign fill_en = fill_valid && !flush;
  assign fill_match = fill_en && (fill_blk == cur_blk);

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match_vec[i]) hit_way = WAY_W'(i);
    end
  end
  assign any_hit = |match_vec;

  always_comb begin
    src = SRC_NONE;
    if (fetch_valid && !flush) begin
      if (fill_match)   src = SRC_FILL;
      else if (any_hit) src = SRC_HIT;
    end
  end

  ilb_tag_store #(.LINES(LINES), .BLK_W(BLK_W)) u_tags (
    .clk(clk), .rst(rst), .flush(flush),
    .fill_en(fill_en), .fill_way(fill_way), .fill_blk(fill_blk),
    .look_blk(cur_blk), .match_vec(match_vec)
  );

  ilb_data_store #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_data (
    .clk(clk), .wr_en(fill_en), .wr_way(fill_way), .wr_line(fill_data),
    .rd_way(hit_way), .rd_sel(cur_sel), .byp_en(src == SRC_FILL),
    .word_q(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_fwd   <= 1'b0;
      miss_req <= 1'b0;
      miss_blk <= '0;
    end else begin
      rd_valid <= (src != SRC_NONE);
      rd_fwd   <= (src == SRC_FILL);
      miss_req <= fetch_valid && !flush && (src == SRC_NONE);
      if (fetch_valid && !flush && src == SRC_NONE) begin
        miss_blk <= cur_blk;
      end
    end
  end

  // R10
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && miss_req));

  // R3
  fwd_implies_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_fwd |-> rd_valid);

  // R3
  miss_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_req && fetch_valid && !flush && fill_valid &&
     fill_blk == miss_blk && cur_blk == miss_blk) |=> (rd_valid && rd_fwd));

  // R2
  miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_req && fetch_valid && !flush && !fill_valid && cur_blk == miss_blk)
      |=> (miss_req && !rd_valid));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> (!rd_valid && !miss_req));
endmodule

// File: tb/iline_buf_bench.sv
module iline_buf_bench;
  localparam int AW = 16;
  localparam int BW = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fill_valid = 1'b0;
  logic [1:0]    fill_way = '0;
  logic [BW-1:0] fill_blk = '0;
  logic [255:0]  fill_data = '0;
  logic          rd_valid, rd_fwd, miss_req;
  logic [31:0]   rd_word;
  logic [BW-1:0] miss_blk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iline_buf u_iline_buf (
    .clk(clk), .rst(rst), .flush(flush),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fill_valid(fill_valid), .fill_way(fill_way), .fill_blk(fill_blk),
    .fill_data(fill_data),
    .rd_valid(rd_valid), .rd_fwd(rd_fwd), .rd_word(rd_word),
    .miss_req(miss_req), .miss_blk(miss_blk)
  );

  function automatic logic [31:0] word_of(logic [BW-1:0] b, int k);
    return {b, 3'(k), 16'h5A3C};
  endfunction

  function automatic logic [255:0] line_of(logic [BW-1:0] b);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[k*32 +: 32] = word_of(b, k);
    return l;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
    n_chk++;
    if (rd_valid && miss_req) begin
      n_fail++;
      $display("FAIL R10: actual rd_valid=1 miss_req=1 expected not both");
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    flush = 0; fetch_valid = 0; fill_valid = 0;
  endtask

  task automatic do_flush();
    idle(); flush = 1; step(); flush = 0;
  endtask

  task automatic load(logic [1:0] w, logic [BW-1:0] b);
    idle(); fill_valid = 1; fill_way = w; fill_blk = b; fill_data = line_of(b);
    step(); fill_valid = 0;
    // R9: fill alone delivers nothing
    chk("R9", {62'd0, rd_valid, miss_req}, 64'd0);
  endtask

  task automatic fetch_hit(logic [AW-1:0] a, string req);
    idle(); fetch_valid = 1; fetch_addr = a; step();
    chk(req, {29'd0, rd_valid, rd_fwd, miss_req, rd_word},
        {29'd0, 3'b100, word_of(a[AW-1:3], int'(a[2:0]))});
  endtask

  task automatic fetch_miss(logic [AW-1:0] a, string req);
    idle(); fetch_valid = 1; fetch_addr = a; step();
    chk(req, {49'd0, rd_valid, miss_req, miss_blk}, {49'd0, 2'b01, a[AW-1:3]});
  endtask

  task automatic t_reset();
    chk("R1", {61'd0, rd_valid, rd_fwd, miss_req}, 64'd0);
    fetch_miss(16'h0040, "R1");
  endtask

  task automatic t_miss_fill();
    fetch_miss(16'h0105, "R2");
    step();
    chk("R2", {49'd0, rd_valid, miss_req, miss_blk}, {49'd0, 2'b01, 13'h0020});
    fill_valid = 1; fill_way = 0; fill_blk = 13'h0020; fill_data = line_of(13'h0020);
    step();
    chk("R3", {29'd0, rd_valid, rd_fwd, miss_req, rd_word},
        {29'd0, 3'b110, word_of(13'h0020, 5)});
    fetch_hit(16'h0100, "R4");
    fetch_hit(16'h0107, "R5");
    fetch_hit(16'h0103, "R5");
    fetch_miss(16'h0108, "R5");
  endtask

  task automatic t_loop();
    do_flush();
    for (int i = 0; i < 4; i++) load(2'(i), 13'h0040 + 13'(i));
    for (int a = 0; a < 32; a++) fetch_hit(16'h0200 + 16'(a), "R7");
  endtask

  task automatic t_replace();
    load(2'd2, 13'h0060);
    fetch_miss(16'h0210, "R6");
    fetch_hit(16'h0304, "R6");
    fetch_hit(16'h0208, "R6");
    fetch_hit(16'h0219, "R6");
  endtask

  task automatic t_flush();
    idle(); flush = 1; fetch_valid = 1; fetch_addr = 16'h0200;
    fill_valid = 1; fill_way = 1; fill_blk = 13'h0070; fill_data = line_of(13'h0070);
    step();
    chk("R8", {62'd0, rd_valid, miss_req}, 64'd0);
    fetch_miss(16'h0200, "R8");
    fetch_miss(16'h0382, "R8");
    idle(); step();
    chk("R9", {62'd0, rd_valid, miss_req}, 64'd0);
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    t_miss_fill();
    t_loop();
    t_replace();
    t_flush();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule